// File: doc/BRIEF.md
# Flash Protected Range Guard

This block decides whether a flash access may go out on the SPI bus. The sequencers send it a start address, a byte length and the kind of access. The guard compares the request against a small bank of protected ranges and answers allow or deny one clock later. An allowed request produces a pulse that starts the SPI cycle. A denied request starts nothing and sets a sticky access-error flag.

Each range word holds a base page, a limit page, a read-protect enable and a write-protect enable. Pages are 4 KiB. A range covers every byte from the first byte of its base page to the last byte of its limit page. Firmware programs the words through a word-indexed write port, where each index stands for one 4-byte register slot. Firmware then raises the lockdown input, which freezes the bank until reset.

Top module: `flash_range_guard`

## Requirements
- R1: After reset every range word reads 0, respValid, respAllow and startCycle are low, accessErr is low, and the bank is unlocked.
- R2: A range word keeps the base page in bits 13:0, the limit page in bits 29:16, the read-protect enable in bit 15 and the write-protect enable in bit 31. Bits 30 and 14 always read 0. cfgIdx selects the word. A write to an index of NUM_RANGES or above changes no word, and reading such an index returns 0.
- R3: reqKind 0 is a read, 1 is a write, and 2 or 3 is an erase. A read is checked only against ranges whose bit 15 is set. A write or an erase is checked only against ranges whose bit 31 is set.
- R4: A read or a write covers the bytes from reqAddr to reqAddr+reqLen, where reqLen is the byte count minus one. The span is not wrapped at the top of the address space. An erase covers the whole 4 KiB page that contains reqAddr, whatever the value of reqLen.
- R5: A range protects the bytes from base*4096 up to limit*4096+0xFFF inclusive. A range with base greater than limit protects nothing. A range with both enables clear is ignored.
- R6: A request is denied when its span overlaps at least one byte of any range that applies to its kind. The answer appears on respValid and respAllow in the cycle after reqValid is sampled.
- R7: startCycle pulses together with the answer only for an allowed request, and never for a denied one.
- R8: A denied answer sets accessErr. The flag stays set until errClr is sampled high. If a deny and errClr arrive in the same cycle, the flag is set.
- R9: lockIn is latched until reset. A register write in the same cycle as lockIn, or in any later cycle, is ignored.
- R10: A request is checked against the bank contents from before any register write sampled in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Range word write strobe |
| cfgIdx | input | IDX_W | Index of the word to write |
| cfgData | input | 32 | Range word write data |
| lockIn | input | 1 | Lockdown request, latched until reset |
| rdIdx | input | IDX_W | Index of the word to read back |
| rdData | output | 32 | Read-back range word (combinational) |
| reqValid | input | 1 | Access request strobe |
| reqAddr | input | ADDR_W | Start byte address of the access |
| reqLen | input | LEN_W | Byte count minus one |
| reqKind | input | 2 | 0 read, 1 write, 2 or 3 erase |
| errClr | input | 1 | Clears the access-error flag |
| respValid | output | 1 | Answer valid, one cycle after reqValid |
| respAllow | output | 1 | 1 when the request is allowed |
| startCycle | output | 1 | Pulse that starts the SPI cycle |
| accessErr | output | 1 | Sticky access-error flag |

## Verification
The bench builds the guard with three ranges, a 16-bit address and a 6-bit length, so the address space is only sixteen pages. At that size, every page crossed with start offsets near both page edges, several lengths and all four kind codes can be swept against range sets that include empty ranges, disabled ranges, single-page ranges and ranges at both ends of the space. Spans that run past the last page and spans that straddle a page boundary all fall within the sweep. The lock, error-flag and same-cycle write orderings are driven in directed sequences.

// File: rtl/frg_pkg.sv
package frg_pkg;

  // Range word field positions (4 KiB page units)
  localparam int PAGE_SHIFT  = 12;
  localparam int PAGE_W      = 14;
  localparam int RNG_BASE_LSB = 0;
  localparam int RNG_LIM_LSB  = 16;
  localparam int RNG_RD_BIT   = 15;
  localparam int RNG_WR_BIT   = 31;
  localparam logic [31:0] RNG_KEEP_MASK = 32'hBFFF_BFFF;

  typedef enum logic [1:0] {
    KIND_READ      = 2'd0,
    KIND_WRITE     = 2'd1,
    KIND_ERASE     = 2'd2,
    KIND_ERASE_ALT = 2'd3
  } frg_kind_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic regWe;
    logic reqTake;
    logic errClr;
    logic frozen;
  } frg_strobes_t;

endpackage

// File: rtl/frg_range_match.sv
module frg_range_match
  import frg_pkg::*;
#(
  parameter int CMP_W = 16
) (
  input  logic [31:0]      rangeWord,
  input  logic             isWrite,
  input  logic [CMP_W-1:0] sPage,
  input  logic [CMP_W-1:0] ePage,
  output logic             hit
);

  logic [CMP_W-1:0] basePg;
  logic [CMP_W-1:0] limPg;
  logic             enabled;

  always_comb begin
    basePg  = CMP_W'(rangeWord[RNG_BASE_LSB +: PAGE_W]);
    limPg   = CMP_W'(rangeWord[RNG_LIM_LSB +: PAGE_W]);
    enabled = isWrite ? rangeWord[RNG_WR_BIT] : rangeWord[RNG_RD_BIT];
    hit     = enabled && (basePg <= limPg) && (basePg <= ePage) && (limPg >= sPage);
  end

endmodule

// File: rtl/frg_ctrl.sv
module frg_ctrl
  import frg_pkg::*;
#(
  parameter int NUM_RANGES = 5,
  parameter int IDX_W      = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         cfgWrEn,
  input  logic [IDX_W-1:0] cfgIdx,
  input  logic         lockIn,
  input  logic         reqValid,
  input  logic         errClr,
  output frg_strobes_t stb
);

  logic lockedQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lockedQ <= 1'b0;
    else       lockedQ <= lockedQ | lockIn;
  end

  always_comb begin
    stb.regWe   = cfgWrEn && !(lockedQ || lockIn) && (cfgIdx < IDX_W'(NUM_RANGES));
    stb.reqTake = reqValid;
    stb.errClr  = errClr;
    stb.frozen  = lockedQ;
  end

  // R9: lockdown stays in force until reset
  a_r9_lock_sticky: assert property (@(posedge clk) disable iff (!rstN)
    lockedQ |=> lockedQ);

endmodule

// File: rtl/frg_datapath.sv
module frg_datapath
  import frg_pkg::*;
#(
  parameter int NUM_RANGES = 5,
  parameter int ADDR_W     = 24,
  parameter int LEN_W      = 6,
  parameter int IDX_W      = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  frg_strobes_t stb,
  input  logic [IDX_W-1:0]  cfgIdx,
  input  logic [31:0]       cfgData,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [31:0]       rdData,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic [1:0]        reqKind,
  output logic         respValid,
  output logic         respAllow,
  output logic         startCycle,
  output logic         accessErr
);

  localparam int SPAN_W = ADDR_W + 1 - PAGE_SHIFT;
  localparam int CMP_W  = (SPAN_W > PAGE_W) ? SPAN_W : PAGE_W;

  logic [31:0]           rangeQ [NUM_RANGES];
  logic [NUM_RANGES-1:0] hitVec;
  logic [ADDR_W:0]       endByte;
  logic [CMP_W-1:0]      sPage;
  logic [CMP_W-1:0]      ePage;
  frg_kind_e             kind;
  logic                  isWrite;
  logic                  isErase;
  logic                  deny;

  // Request span in page units
  always_comb begin
    kind    = frg_kind_e'(reqKind);
    isWrite = (kind != KIND_READ);
    isErase = (kind == KIND_ERASE) || (kind == KIND_ERASE_ALT);
    endByte = {1'b0, reqAddr} + (ADDR_W+1)'(reqLen);
    sPage   = CMP_W'(reqAddr[ADDR_W-1:PAGE_SHIFT]);
    ePage   = isErase ? sPage : CMP_W'(endByte[ADDR_W:PAGE_SHIFT]);
  end

  for (genvar r = 0; r < NUM_RANGES; r++) begin : g_range
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        rangeQ[r] <= '0;
      else if (stb.regWe && (cfgIdx == IDX_W'(r)))
        rangeQ[r] <= cfgData & RNG_KEEP_MASK;
    end

    frg_range_match #(.CMP_W(CMP_W)) i_match (
      .rangeWord(rangeQ[r]),
      .isWrite  (isWrite),
      .sPage    (sPage),
      .ePage    (ePage),
      .hit      (hitVec[r])
    );

    // R9: a locked bank never changes
    a_r9_frozen_word: assert property (@(posedge clk) disable iff (!rstN)
      stb.frozen |=> $stable(rangeQ[r]));
  end

  assign deny = |hitVec;

  always_comb begin
    rdData = '0;
    for (int r = 0; r < NUM_RANGES; r++)
      if (rdIdx == IDX_W'(r)) rdData = rangeQ[r];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respValid  <= 1'b0;
      respAllow  <= 1'b0;
      startCycle <= 1'b0;
      accessErr  <= 1'b0;
    end else begin
      respValid  <= stb.reqTake;
      respAllow  <= stb.reqTake && !deny;
      startCycle <= stb.reqTake && !deny;
      if (stb.reqTake && deny) accessErr <= 1'b1;
      else if (stb.errClr)     accessErr <= 1'b0;
    end
  end

  // R6: every sampled request is answered one cycle later
  a_r6_resp_follows_req: assert property (@(posedge clk) disable iff (!rstN)
    stb.reqTake |=> respValid);

  // R7: no SPI cycle without an allowed answer
  a_r7_start_needs_allow: assert property (@(posedge clk) disable iff (!rstN)
    startCycle |-> (respValid && respAllow));

  // R8: a deny is always reflected in the error flag
  a_r8_deny_flags_err: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !respAllow) |-> accessErr);

  // R8: the flag only drops on a clear
  a_r8_err_holds: assert property (@(posedge clk) disable iff (!rstN)
    (accessErr && !stb.errClr) |=> accessErr);

endmodule

// File: rtl/flash_range_guard.sv
module flash_range_guard
  import frg_pkg::*;
#(
  parameter int NUM_RANGES = 5,
  parameter int ADDR_W     = 24,
  parameter int LEN_W      = 6,
  parameter int IDX_W      = $clog2(NUM_RANGES) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [IDX_W-1:0]  cfgIdx,
  input  logic [31:0]       cfgData,
  input  logic              lockIn,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [31:0]       rdData,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic [1:0]        reqKind,
  input  logic              errClr,
  output logic              respValid,
  output logic              respAllow,
  output logic              startCycle,
  output logic              accessErr
);

  frg_strobes_t stb;

  frg_ctrl #(.NUM_RANGES(NUM_RANGES), .IDX_W(IDX_W)) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cfgWrEn (cfgWrEn),
    .cfgIdx  (cfgIdx),
    .lockIn  (lockIn),
    .reqValid(reqValid),
    .errClr  (errClr),
    .stb     (stb)
  );

  frg_datapath #(
    .NUM_RANGES(NUM_RANGES), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .IDX_W(IDX_W)
  ) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .cfgIdx    (cfgIdx),
    .cfgData   (cfgData),
    .rdIdx     (rdIdx),
    .rdData    (rdData),
    .reqAddr   (reqAddr),
    .reqLen    (reqLen),
    .reqKind   (reqKind),
    .respValid (respValid),
    .respAllow (respAllow),
    .startCycle(startCycle),
    .accessErr (accessErr)
  );

endmodule

// File: tb/test_flash_range_guard.sv
module test_flash_range_guard;

  localparam int NR = 3;
  localparam int AW = 16;
  localparam int LW = 6;
  localparam int IW = $clog2(NR) + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [IW-1:0] cfgIdx = '0;
  logic [31:0] cfgData = '0;
  logic lockIn = 1'b0;
  logic [IW-1:0] rdIdx = '0;
  logic [31:0] rdData;
  logic reqValid = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [LW-1:0] reqLen = '0;
  logic [1:0] reqKind = '0;
  logic errClr = 1'b0;
  logic respValid, respAllow, startCycle, accessErr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit lockedM = 1'b0;
  bit errExp = 1'b0;
  logic [31:0] shadow [NR];

  always #5 clk = ~clk;

  flash_range_guard #(.NUM_RANGES(NR), .ADDR_W(AW), .LEN_W(LW), .IDX_W(IW)) i_flash_range_guard (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgIdx(cfgIdx), .cfgData(cfgData),
    .lockIn(lockIn), .rdIdx(rdIdx), .rdData(rdData), .reqValid(reqValid),
    .reqAddr(reqAddr), .reqLen(reqLen), .reqKind(reqKind), .errClr(errClr),
    .respValid(respValid), .respAllow(respAllow), .startCycle(startCycle),
    .accessErr(accessErr)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic bit expDeny(int unsigned addr, int unsigned len, int kind);
    int unsigned sp, ep, b, l;
    bit en;
    sp = addr >> 12;
    ep = (kind >= 2) ? sp : ((addr + len) >> 12);
    for (int r = 0; r < NR; r++) begin
      en = (kind == 0) ? shadow[r][15] : shadow[r][31];
      b = shadow[r][13:0];
      l = shadow[r][29:16];
      if (en && b <= l && b <= ep && l >= sp) return 1'b1;
    end
    return 1'b0;
  endfunction

  task automatic writeWord(input int idx, input logic [31:0] data, input bit lockNow);
    cfgWrEn = 1'b1; cfgIdx = IW'(idx); cfgData = data; lockIn = lockNow;
    @(negedge clk);
    cfgWrEn = 1'b0; lockIn = 1'b0;
    if (lockNow) lockedM = 1'b1;
    if (!lockedM && idx < NR) shadow[idx] = data & 32'hBFFF_BFFF;
  endtask

  task automatic readCheck(input int idx, input string tag);
    rdIdx = IW'(idx);
    #1;
    check(rdData, (idx < NR) ? shadow[idx] : 32'h0, tag);
  endtask

  task automatic doReq(input int unsigned addr, input int unsigned len, input int kind,
                       input bit clr, input string tag);
    bit d;
    d = expDeny(addr, len, kind);
    reqValid = 1'b1; reqAddr = AW'(addr); reqLen = LW'(len); reqKind = 2'(kind); errClr = clr;
    @(negedge clk);
    reqValid = 1'b0; errClr = 1'b0;
    if (d) errExp = 1'b1;
    else if (clr) errExp = 1'b0;
    check({31'b0, respValid}, 32'd1, {tag, " respValid"});
    check({31'b0, respAllow}, {31'b0, !d}, {tag, " respAllow"});
    check({31'b0, startCycle}, {31'b0, !d}, {tag, " startCycle"});
    check({31'b0, accessErr}, {31'b0, errExp}, {tag, " accessErr"});
  endtask

  task automatic clearErr();
    errClr = 1'b1;
    @(negedge clk);
    errClr = 1'b0;
    errExp = 1'b0;
    check({31'b0, accessErr}, 32'd0, "R8 clear");
  endtask

  task automatic sweep(input string tag);
    int offs [4] = '{0, 32'h7FF, 32'hFC1, 32'hFFF};
    int lens [4] = '{0, 1, 30, 63};
    for (int p = 0; p < 16; p++)
      for (int o = 0; o < 4; o++)
        for (int n = 0; n < 4; n++)
          for (int k = 0; k < 4; k++)
            doReq(p * 4096 + offs[o], lens[n], k, 1'b0, tag);
    @(negedge clk);
    check({31'b0, respValid}, 32'd0, "R6 idle no response");
    check({31'b0, startCycle}, 32'd0, "R7 idle no start");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < NR; r++) shadow[r] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check({31'b0, respValid}, 32'd0, "R1 respValid");
    check({31'b0, respAllow}, 32'd0, "R1 respAllow");
    check({31'b0, startCycle}, 32'd0, "R1 startCycle");
    check({31'b0, accessErr}, 32'd0, "R1 accessErr");
    for (int r = 0; r < NR; r++) readCheck(r, "R1 word");

    // R2 field layout and out-of-range index
    writeWord(0, 32'hFFFF_FFFF, 1'b0);
    readCheck(0, "R2 masked bits");
    writeWord(1, 32'h1234_5678, 1'b0);
    readCheck(1, "R2 word1");
    writeWord(NR, 32'hFFFF_FFFF, 1'b0);
    readCheck(NR, "R2 high index reads 0");
    for (int r = 0; r < NR; r++) readCheck(r, "R2 high index write ignored");

    // R3 R4 R5 R6 R7 sweep, set A: read-only, write-only, both
    writeWord(0, 32'h0003_8002, 1'b0);
    writeWord(1, 32'h8005_0005, 1'b0);
    writeWord(2, 32'h800C_8009, 1'b0);
    clearErr();
    sweep("R3/R4/R6 setA");

    // R5 set B: empty range, disabled range, top page
    writeWord(0, 32'h8004_8007, 1'b0);
    writeWord(1, 32'h000F_0000, 1'b0);
    writeWord(2, 32'h800F_000F, 1'b0);
    clearErr();
    sweep("R5 setB");

    // set C: single pages at the bottom
    writeWord(0, 32'h8000_8000, 1'b0);
    writeWord(1, 32'h0008_8008, 1'b0);
    writeWord(2, 32'h8001_0001, 1'b0);
    clearErr();
    sweep("R4/R7 setC");

    // R8 sticky flag, clear, and set winning over clear
    clearErr();
    doReq(32'h3000, 0, 0, 1'b0, "R8 allowed keeps flag low");
    doReq(32'h0000, 0, 0, 1'b0, "R8 deny sets flag");
    doReq(32'h3000, 0, 0, 1'b0, "R8 flag stays after allow");
    clearErr();
    doReq(32'h0010, 4, 1, 1'b1, "R8 deny beats clear");
    check({31'b0, accessErr}, 32'd1, "R8 deny beats clear flag");

    // R10 request sees bank before same-cycle write
    clearErr();
    cfgWrEn = 1'b1; cfgIdx = IW'(1); cfgData = 32'h0003_8003;
    doReq(32'h3000, 0, 0, 1'b0, "R10 old bank used");
    cfgWrEn = 1'b0;
    shadow[1] = 32'h0003_8003;
    doReq(32'h3000, 0, 0, 1'b0, "R10 new bank next cycle");

    // R9 lockdown: same-cycle write and later writes ignored
    writeWord(2, 32'h0, 1'b1);
    readCheck(2, "R9 same-cycle write ignored");
    writeWord(0, 32'h0, 1'b0);
    readCheck(0, "R9 later write ignored");
    writeWord(1, 32'h0, 1'b0);
    readCheck(1, "R9 later write ignored");
    clearErr();
    doReq(32'h1004, 0, 2, 1'b0, "R9 locked bank still guards");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule